// File: doc/BRIEF.md
# Host bridge memory decoder lookup

This block models one host-managed memory decoder inside a host bridge. Software programs a control word and two target-list words through a small write port. A requester then presents a host physical address with a one-cycle strobe. One cycle later the block reports whether the decoder claims the address and, if it does, which downstream port owns it.

The control word carries a commit bit, an interleave granularity code and an interleave ways code. The address is divided by the decoded granularity and reduced modulo the number of ways. The result is the interleave position. That position selects one byte-wide port number from the eight packed into the two target-list words.

A decoder that is not committed claims nothing. Nor does one whose granularity or ways code lies outside the supported range.

Top module: `hbr_decode_lookup`

## Requirements
- R1: While the commit bit (control bit 10) is 0, every lookup reports a miss.
- R2: A write with `wr_en` high loads `wr_data` into the control word when `wr_sel` is 0, the low target word when it is 1 and the high target word when it is 2. A write with `wr_sel` equal to 3 changes nothing that later lookups can observe.
- R3: The granularity code sits in control bits 3:0 and the ways code sits in control bits 7:4. The other control bits have no effect.
- R4: The decoded granularity is 256 bytes shifted left by the granularity code, for codes 0 to 6. A code above 6 makes every lookup miss.
- R5: The interleave position is (address / granularity) mod 2^ways, for ways codes 0 to 3. A ways code above 3 makes every lookup miss.
- R6: Entries 0 to 3 are read from the low target word, with entry n in bits 8n+7:8n. Entries 4 to 7 are read from the high word, with entry n in bits 8(n-4)+7:8(n-4). On a hit the selected entry appears on `res_port`.
- R7: `res_vld` is high exactly in the cycle after a cycle in which `addr_vld` was high. The result reflects the address and the register contents at that strobe.
- R8: On a miss `res_port` is 0. Between strobes `res_hit` and `res_port` hold their last values, even when the registers are rewritten.
- R9: After reset the outputs are 0 and all three registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 low targets, 2 high targets, 3 none |
| wr_data | input | 32 | Register write data |
| addr_vld | input | 1 | Lookup strobe |
| addr | input | 52 | Host physical address to decode |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | Decoder claims the address |
| res_port | output | 8 | Downstream port number on a hit, 0 on a miss |

## Verification
A register write is applied on the clock edge on which `wr_en` is sampled, so it affects a strobe presented on the following cycle. A lookup result is due one edge after its strobe. `res_vld` must fall again one edge later, while `res_hit` and `res_port` hold.

The bench drives every input on the falling edge. It reads the result on the falling edge that follows the capturing rising edge. It then reads the outputs one cycle later, to confirm that `res_vld` has dropped and the held values are unchanged.

// File: rtl/hbr_dec_pkg.sv
package hbr_dec_pkg;
  localparam int GRAN_SHIFT = 8;   // 256-byte base granularity
  localparam int CODE_W     = 4;
  localparam int IG_LSB     = 0;
  localparam int IW_LSB     = 4;
  localparam int COMMIT_BIT = 10;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_TGT_LO = 2'd1,
    SEL_TGT_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              commit;
    logic [CODE_W-1:0] iw;
    logic [CODE_W-1:0] ig;
  } ctrl_s;
endpackage

// File: rtl/hbr_dec_regs.sv
module hbr_dec_regs
  import hbr_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_s             ctrl,
  output logic [DATA_W-1:0] tgt_lo,
  output logic [DATA_W-1:0] tgt_hi
);
  ctrl_s             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    ctrl_d = ctrl_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CTRL: begin
          ctrl_d.commit = wr_data[COMMIT_BIT];
          ctrl_d.iw     = wr_data[IW_LSB +: CODE_W];
          ctrl_d.ig     = wr_data[IG_LSB +: CODE_W];
        end
        SEL_TGT_LO: lo_d = wr_data;
        SEL_TGT_HI: hi_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign tgt_lo = lo_q;
  assign tgt_hi = hi_q;

  AST_SEL_NONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q))); // R2
  AST_IDLE_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q))); // R2
endmodule

// File: rtl/hbr_dec_index.sv
module hbr_dec_index
  import hbr_dec_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int POS_W  = 3,
  parameter int IG_MAX = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] ig,
  input  logic [CODE_W-1:0] iw,
  output logic [POS_W-1:0]  pos,
  output logic              fmt_ok
);
  localparam logic [CODE_W-1:0] IG_LIM = CODE_W'(IG_MAX);
  localparam logic [CODE_W-1:0] IW_LIM = CODE_W'(POS_W);

  logic [POS_W-1:0] pos_raw;
  logic [POS_W-1:0] way_mask;

  always_comb begin
    pos_raw = POS_W'(addr >> (GRAN_SHIFT + int'(ig)));
    for (int i = 0; i < POS_W; i++) begin
      way_mask[i] = (i < int'(iw));
    end
    pos    = pos_raw & way_mask;
    fmt_ok = (ig <= IG_LIM) && (iw <= IW_LIM);
  end
endmodule

// File: rtl/hbr_dec_pick.sv
module hbr_dec_pick #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  parameter int POS_W  = 3
) (
  input  logic [DATA_W-1:0] tgt_lo,
  input  logic [DATA_W-1:0] tgt_hi,
  input  logic [POS_W-1:0]  pos,
  output logic [PORT_W-1:0] port
);
  localparam int EPW   = DATA_W / PORT_W;
  localparam int N_ENT = 2 * EPW;

  logic [PORT_W-1:0] entry [N_ENT];

  for (genvar n = 0; n < N_ENT; n++) begin : g_ent
    if (n < EPW) begin : g_lo
      assign entry[n] = tgt_lo[n*PORT_W +: PORT_W];
    end else begin : g_hi
      assign entry[n] = tgt_hi[(n-EPW)*PORT_W +: PORT_W];
    end
  end

  assign port = entry[pos];
endmodule

// File: rtl/hbr_decode_lookup.sv
module hbr_decode_lookup
  import hbr_dec_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  parameter int IG_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              res_vld,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port
);
  localparam int N_ENT = 2 * (DATA_W / PORT_W);
  localparam int POS_W = $clog2(N_ENT);
  localparam logic [CODE_W-1:0] IW_LIM = CODE_W'(POS_W);

  ctrl_s             ctrl;
  logic [DATA_W-1:0] tgt_lo, tgt_hi;
  logic [POS_W-1:0]  pos;
  logic              fmt_ok;
  logic [PORT_W-1:0] pick_port;

  logic              vld_q, hit_q, hit_d;
  logic [PORT_W-1:0] port_q, port_d;

  hbr_dec_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl(ctrl), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi)
  );

  hbr_dec_index #(.ADDR_W(ADDR_W), .POS_W(POS_W), .IG_MAX(IG_MAX)) u_index (
    .addr(addr), .ig(ctrl.ig), .iw(ctrl.iw), .pos(pos), .fmt_ok(fmt_ok)
  );

  hbr_dec_pick #(.DATA_W(DATA_W), .PORT_W(PORT_W), .POS_W(POS_W)) u_pick (
    .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .pos(pos), .port(pick_port)
  );

  always_comb begin
    hit_d  = ctrl.commit && fmt_ok;
    port_d = hit_d ? pick_port : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      port_q <= '0;
    end else begin
      vld_q <= addr_vld;
      if (addr_vld) begin
        hit_q  <= hit_d;
        port_q <= port_d;
      end
    end
  end

  assign res_vld  = vld_q;
  assign res_hit  = hit_q;
  assign res_port = port_q;

  AST_UNCOMMITTED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !ctrl.commit) |=> !res_hit); // R1
  AST_BAD_GRAN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && ctrl.ig > CODE_W'(IG_MAX)) |=> !res_hit); // R4
  AST_BAD_WAYS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && ctrl.iw > IW_LIM) |=> !res_hit); // R5
  AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> res_vld); // R7
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !res_vld); // R7
  AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_port == '0); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ($stable(res_hit) && $stable(res_port))); // R8
endmodule

// File: tb/sim_hbr_decode_lookup.sv
module sim_hbr_decode_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        addr_vld = 1'b0;
  logic [51:0] addr = '0;
  logic        res_vld, res_hit;
  logic [7:0]  res_port;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_ctrl = '0, sh_lo = '0, sh_hi = '0;

  always #2 clk = ~clk;  // 250 MHz

  hbr_decode_lookup u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_vld(addr_vld), .addr(addr), .res_vld(res_vld), .res_hit(res_hit),
    .res_port(res_port)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [51:0] a);
    logic [3:0] ig, iw;
    logic [2:0] p;
    logic [7:0] prt;
    ig = sh_ctrl[3:0];
    iw = sh_ctrl[7:4];
    if (!sh_ctrl[10] || ig > 4'd6 || iw > 4'd3) return 9'd0;
    p = 3'((a >> (8 + int'(ig))) & ((52'd1 << iw) - 52'd1));
    prt = (p < 3'd4) ? sh_lo[8*p +: 8] : sh_hi[8*(p-3'd4) +: 8];
    return {1'b1, prt};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'd0) sh_ctrl = d;
    else if (sel == 2'd1) sh_lo = d;
    else if (sel == 2'd2) sh_hi = d;
  endtask

  function automatic logic [31:0] cw(input bit c, input logic [3:0] iw,
                                     input logic [3:0] ig);
    return (32'(c) << 10) | (32'(iw) << 4) | 32'(ig);
  endfunction

  task automatic look(input logic [51:0] a, input string req);
    logic [8:0] e;
    e = model(a);
    @(negedge clk);
    addr_vld = 1'b1; addr = a;
    @(negedge clk);
    addr_vld = 1'b0;
    chk(res_vld === 1'b1, "R7 valid after strobe", 64'(res_vld), 64'd1);
    chk(res_hit === e[8], req, 64'(res_hit), 64'(e[8]));
    chk(res_port === e[7:0], req, 64'(res_port), 64'(e[7:0]));
    @(negedge clk);
    chk(res_vld === 1'b0, "R7 valid one cycle only", 64'(res_vld), 64'd0);
    chk(res_hit === e[8] && res_port === e[7:0], "R8 hold",
        64'({res_hit, res_port}), 64'(e));
  endtask

  task automatic t_reset();
    chk(res_vld === 0 && res_hit === 0 && res_port === 0, "R9 reset outputs",
        64'({res_vld, res_hit, res_port}), 64'd0);
    look(52'h100, "R9 reset regs give miss");
  endtask

  task automatic t_uncommitted();
    wr(2'd1, 32'h0D0C0B0A);
    wr(2'd2, 32'h14131211);
    wr(2'd0, cw(0, 4'd1, 4'd0));
    look(52'h100, "R1 uncommitted miss");
    look(52'h000, "R1 uncommitted miss port zero");
  endtask

  task automatic t_single();
    wr(2'd0, cw(1, 4'd0, 4'd0) | 32'hFFFF_F800);  // R3 unused control bits set
    look(52'h12345, "R3 R5 single way");
    look(52'hF_FFFF_FFFF_FF00, "R5 single way high address");
  endtask

  task automatic t_two_way();
    wr(2'd0, cw(1, 4'd1, 4'd0));
    look(52'h000, "R5 two way pos0");
    look(52'h100, "R5 two way pos1");
    look(52'h2FF, "R4 two way 256B boundary");
  endtask

  task automatic t_four_way();
    wr(2'd0, cw(1, 4'd2, 4'd2));
    look(52'h3FF, "R4 1KiB gran pos0");
    look(52'h400, "R4 1KiB gran pos1");
    look(52'hC00, "R4 1KiB gran pos3");
    look(52'h1000, "R5 four way wrap");
  endtask

  task automatic t_eight_way();
    wr(2'd0, cw(1, 4'd3, 4'd6));
    for (int n = 0; n < 8; n++) look(52'(n) << 14, "R6 entry packing");
    look(52'h8_0000 | (52'd5 << 14), "R6 wrap to entry5");
  endtask

  task automatic t_bad_codes();
    wr(2'd0, cw(1, 4'd0, 4'd7));
    look(52'h0, "R4 gran code 7 miss");
    wr(2'd0, cw(1, 4'd4, 4'd0));
    look(52'h0, "R5 ways code 4 miss");
  endtask

  task automatic t_ignored_sel();
    wr(2'd0, cw(1, 4'd1, 4'd0));
    wr(2'd3, 32'hFFFF_FFFF);
    look(52'h000, "R2 select 3 ignored");
    look(52'h100, "R2 select 3 ignored");
  endtask

  task automatic t_hold();
    logic [8:0] e;
    wr(2'd0, cw(1, 4'd0, 4'd0));
    look(52'h0, "R7 lookup");
    e = {1'b1, sh_lo[7:0]};
    wr(2'd1, 32'h0D0C0B77);
    repeat (3) @(negedge clk);
    chk(res_vld === 0 && res_hit === e[8] && res_port === e[7:0],
        "R8 hold across rewrite", 64'({res_vld, res_hit, res_port}), 64'(e));
    look(52'h0, "R2 new low word seen");
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uncommitted();
    t_single();
    t_two_way();
    t_four_way();
    t_eight_way();
    t_bad_codes();
    t_ignored_sel();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule